// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block listens passively to the clock and data lines of a two-wire serial bus and turns them into clean, single-cycle events in the system clock domain. Each line is brought into the system clock domain by a short flop chain. It then passes through a spike filter, so a level is accepted only after it has held steady for a set number of cycles. The filtered lines are then decoded into bus conditions.

A falling data line while the clock is high opens a transfer and marks the bus busy. A rising data line while the clock is high closes it. Between the two, one data bit is recovered per clock pulse and presented on the falling clock edge. A clock pulse seen while no transfer is open is reported as a protocol violation. Byte assembly, address matching and acknowledge handling sit in the logic that consumes these events.

Top module: `twb_cond_mon`

## Requirements
- R1: While `rst` is high at a clock edge and after it, every strobe, `busy_o`, `viol_o` and `bit_o` read 0, and both filtered lines are taken as high (idle).
- R2: Each input passes a two-flop synchroniser and then a filter. The filter accepts a new level only after the synchronised input has differed from the accepted level for `FILT_LEN` consecutive cycles (default 4). A shorter pulse has no effect on any output. A clean change shows on the outputs at the `FILT_LEN`+3rd rising clock edge after it.
- R3: A filtered data fall while the filtered clock stays high pulses `start_o` for one cycle and sets `busy_o` in that same cycle.
- R4: A filtered data rise while the filtered clock stays high pulses `stop_o` for one cycle and clears `busy_o` in that same cycle.
- R5: A Start detected while `busy_o` is already 1 also pulses `rstart_o`, and `busy_o` stays 1.
- R6: On each filtered clock fall while busy, `bit_vld_o` pulses for one cycle. In that cycle `bit_o` shows the filtered data level captured at the preceding filtered clock rise (1 = line high).
- R7: If a Start or Stop occurred during a clock-high period, the `bit_vld_o` pulse for the following clock fall is suppressed.
- R8: A filtered clock rise while `busy_o` is 0 pulses `viol_o` for one cycle. `viol_o` is never 1 together with `busy_o`.
- R9: `bit_o` changes only in a cycle where `bit_vld_o` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| start_o | output | 1 | One-cycle Start strobe |
| stop_o | output | 1 | One-cycle Stop strobe |
| rstart_o | output | 1 | One-cycle repeated-Start strobe |
| bit_vld_o | output | 1 | One-cycle recovered-bit strobe |
| bit_o | output | 1 | Last recovered data bit |
| busy_o | output | 1 | Transfer open (between Start and Stop) |
| viol_o | output | 1 | One-cycle clock-pulse-while-idle flag |

## Verification
The lines are driven with spikes of two and three cycles on both the data and clock lines, while idle and inside a transfer. These show that sub-threshold pulses leave every output untouched. A transfer with mixed bit values, a repeated Start inside it, and a closing Stop tells real bit recovery apart from strobes that a condition should suppress. A lone clock pulse after the Stop separates the violation path from bit recovery. A behavioural model tracks every output on every cycle, which pins the exact latency as well as the values.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef struct packed {
        logic busy;
        logic samp;
        logic cond_seen;
        logic scl_prev;
        logic sda_prev;
        logic start;
        logic stop;
        logic rstart;
        logic bvld;
        logic bit_v;
        logic viol;
    } dec_state_t;

    localparam int unsigned LANES    = 2;
    localparam int unsigned LANE_SCL = 0;
    localparam int unsigned LANE_SDA = 1;

endpackage

// File: rtl/twb_deglitch.sv
module twb_deglitch #(
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic filt_o
);
    localparam int unsigned CW = $clog2(FILT_LEN) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   filt;
    } flt_state_t;

    flt_state_t st_d, st_q;
    logic       synced;

    assign synced = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d = st_q;
        if (SYNC_STAGES > 1) begin
            st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw_in};
        end else begin
            st_d.sync = raw_in;
        end
        if (synced == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LIMIT) begin
            st_d.cnt  = '0;
            st_d.filt = synced;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sync <= '1;
            st_q.cnt  <= '0;
            st_q.filt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.filt;

    // R2: the accepted level moves only once the counter has reached its limit
    a_r2_filter_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q.filt != $past(st_q.filt)) |-> ($past(st_q.cnt) == LIMIT));

    // R2: the accepted level only ever moves toward the synchronised level
    a_r2_filter_dir: assert property (@(posedge clk) disable iff (rst)
        (st_q.filt != $past(st_q.filt)) |-> (st_q.filt == $past(synced)));

endmodule

// File: rtl/twb_cond_decode.sv
module twb_cond_decode
    import twb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic rstart_o,
    output logic bit_vld_o,
    output logic bit_o,
    output logic busy_o,
    output logic viol_o
);
    dec_state_t st_d, st_q;
    logic start_ev, stop_ev, scl_rise, scl_fall;

    always_comb begin
        start_ev = scl_f & st_q.scl_prev & st_q.sda_prev & ~sda_f;
        stop_ev  = scl_f & st_q.scl_prev & ~st_q.sda_prev & sda_f;
        scl_rise = scl_f & ~st_q.scl_prev;
        scl_fall = ~scl_f & st_q.scl_prev;

        st_d          = st_q;
        st_d.scl_prev = scl_f;
        st_d.sda_prev = sda_f;
        st_d.start    = start_ev;
        st_d.stop     = stop_ev;
        st_d.rstart   = start_ev & st_q.busy;
        st_d.bvld     = scl_fall & st_q.busy & ~st_q.cond_seen;
        st_d.viol     = scl_rise & ~st_q.busy;

        if (st_d.bvld) begin
            st_d.bit_v = st_q.samp;
        end
        if (scl_rise) begin
            st_d.samp      = sda_f;
            st_d.cond_seen = 1'b0;
        end
        if (start_ev || stop_ev) begin
            st_d.cond_seen = 1'b1;
        end
        if (start_ev) begin
            st_d.busy = 1'b1;
        end else if (stop_ev) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= '0;
            st_q.scl_prev <= 1'b1;
            st_q.sda_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o   = st_q.start;
    assign stop_o    = st_q.stop;
    assign rstart_o  = st_q.rstart;
    assign bit_vld_o = st_q.bvld;
    assign bit_o     = st_q.bit_v;
    assign busy_o    = st_q.busy;
    assign viol_o    = st_q.viol;

    // R3: a Start strobe comes with the busy flag set
    a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
        start_o |-> busy_o);

    // R4: a Stop strobe comes with the busy flag cleared
    a_r4_stop_idle: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> !busy_o);

    // R3 R4: Start and Stop never coincide
    a_r4_excl: assert property (@(posedge clk) disable iff (rst)
        !(start_o && stop_o));

    // R5: a repeated Start is a Start seen while already busy
    a_r5_rstart: assert property (@(posedge clk) disable iff (rst)
        rstart_o |-> (start_o && $past(busy_o)));

    // R6: a recovered bit is only issued from a busy bus
    a_r6_bit_busy: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |-> $past(busy_o));

    // R8: the violation flag never coexists with busy
    a_r8_viol_idle: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> !busy_o);

    // R9: the bit output holds between bit strobes
    a_r9_bit_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_vld_o |-> $stable(bit_o));

endmodule

// File: rtl/twb_cond_mon.sv
module twb_cond_mon
    import twb_pkg::*;
#(
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_o,
    output logic stop_o,
    output logic rstart_o,
    output logic bit_vld_o,
    output logic bit_o,
    output logic busy_o,
    output logic viol_o
);
    logic [LANES-1:0] raw_lines;
    logic [LANES-1:0] filt_lines;

    assign raw_lines[LANE_SCL] = scl_in;
    assign raw_lines[LANE_SDA] = sda_in;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        twb_deglitch #(
            .FILT_LEN    (FILT_LEN),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_flt (
            .clk    (clk),
            .rst    (rst),
            .raw_in (raw_lines[g]),
            .filt_o (filt_lines[g])
        );
    end

    twb_cond_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .scl_f     (filt_lines[LANE_SCL]),
        .sda_f     (filt_lines[LANE_SDA]),
        .start_o   (start_o),
        .stop_o    (stop_o),
        .rstart_o  (rstart_o),
        .bit_vld_o (bit_vld_o),
        .bit_o     (bit_o),
        .busy_o    (busy_o),
        .viol_o    (viol_o)
    );

    // R1: with reset applied the block reports idle and quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !(start_o || stop_o || rstart_o || bit_vld_o || busy_o || viol_o));

endmodule

// File: tb/twb_cond_mon_bench.sv
module twb_cond_mon_bench;
    localparam int FL = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic start_o, stop_o, rstart_o, bit_vld_o, bit_o, busy_o, viol_o;

    int total = 0;
    int bad   = 0;
    int n_start = 0, n_stop = 0, n_rstart = 0, n_bits = 0, n_viol = 0;
    bit bits_q[$];

    always #2.5 clk = ~clk;

    twb_cond_mon #(.FILT_LEN(FL)) u_twb_cond_mon (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
        .start_o(start_o), .stop_o(stop_o), .rstart_o(rstart_o),
        .bit_vld_o(bit_vld_o), .bit_o(bit_o), .busy_o(busy_o), .viol_o(viol_o)
    );

    // behavioural reference: pipeline of lists per line plus event rules
    bit m_s1[2], m_s2[2], m_f[2];
    int m_cnt[2];
    bit m_ps, m_pd, m_busy, m_samp, m_seen;
    bit m_start, m_stop, m_rstart, m_bv, m_bit, m_viol;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 1; m_s2[i] = 1; m_f[i] = 1; m_cnt[i] = 0;
            end
            m_ps = 1; m_pd = 1; m_busy = 0; m_samp = 0; m_seen = 0;
            m_start = 0; m_stop = 0; m_rstart = 0; m_bv = 0; m_bit = 0; m_viol = 0;
        end else begin
            bit s, d, st_e, sp_e, rise, fall;
            s = m_f[0]; d = m_f[1];
            st_e = s && m_ps && m_pd && !d;
            sp_e = s && m_ps && !m_pd && d;
            rise = s && !m_ps;
            fall = !s && m_ps;
            m_start  = st_e;
            m_stop   = sp_e;
            m_rstart = st_e && m_busy;
            m_bv     = fall && m_busy && !m_seen;
            if (m_bv) m_bit = m_samp;
            m_viol   = rise && !m_busy;
            if (rise) begin m_samp = d; m_seen = 0; end
            if (st_e || sp_e) m_seen = 1;
            if (st_e) m_busy = 1; else if (sp_e) m_busy = 0;
            m_ps = s; m_pd = d;
            for (int i = 0; i < 2; i++) begin
                if (m_s2[i] == m_f[i]) m_cnt[i] = 0;
                else if (m_cnt[i] == FL - 1) begin m_f[i] = m_s2[i]; m_cnt[i] = 0; end
                else m_cnt[i]++;
                m_s2[i] = m_s1[i];
            end
            m_s1[0] = scl; m_s1[1] = sda;
        end
    end

    task automatic chk(input string req, input string name, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string name, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
        end
    endtask

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R3", "start_o",   start_o,   m_start);
            chk("R4", "stop_o",    stop_o,    m_stop);
            chk("R5", "rstart_o",  rstart_o,  m_rstart);
            chk("R6", "bit_vld_o", bit_vld_o, m_bv);
            chk("R9", "bit_o",     bit_o,     m_bit);
            chk("R3", "busy_o",    busy_o,    m_busy);
            chk("R8", "viol_o",    viol_o,    m_viol);
            if (start_o)   n_start++;
            if (stop_o)    n_stop++;
            if (rstart_o)  n_rstart++;
            if (viol_o)    n_viol++;
            if (bit_vld_o) begin n_bits++; bits_q.push_back(bit_o); end
        end
    end

    task automatic hold(input logic c, input logic d, input int cyc);
        @(negedge clk);
        scl = c; sda = d;
        repeat (cyc - 1) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        hold(0, b, 10);
        hold(1, b, 10);
        hold(0, b, 10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit exp_bits[6] = '{1, 0, 1, 1, 0, 1};
        repeat (6) @(negedge clk);
        // R1: reset state, checked while reset is still applied
        chk("R1", "start_o in reset", start_o, 0);
        chk("R1", "busy_o in reset",  busy_o,  0);
        chk("R1", "bit_o in reset",   bit_o,   0);
        chk("R1", "viol_o in reset",  viol_o,  0);
        rst = 0;
        hold(1, 1, 12);

        // R2: sub-threshold spikes on data while idle and clock high
        hold(1, 0, 2);  hold(1, 1, 12);
        hold(1, 0, 3);  hold(1, 1, 12);
        // R2: sub-threshold spike on clock while idle
        hold(0, 1, 3);  hold(1, 1, 12);
        chk_int("R2", "starts after data spikes", n_start, 0);
        chk_int("R2", "viol after clock spike",   n_viol, 0);
        chk("R2", "busy_o after spikes", busy_o, 0);

        // R3: Start, then check the exact latency of FL+3 edges
        @(negedge clk); sda = 0;
        repeat (FL + 2) @(negedge clk);
        chk("R2", "start_o one edge early", start_o, 0);
        @(negedge clk);
        chk("R2", "start_o at FL+3 edges", start_o, 1);
        hold(1, 0, 8);
        hold(0, 0, 10);

        send_bit(1); send_bit(0);
        // R2: short data spike during clock high inside a transfer
        hold(0, 1, 10); hold(1, 1, 6); hold(1, 0, 3); hold(1, 1, 6); hold(0, 1, 10);
        send_bit(1);

        // R5/R7: repeated Start inside a clock-high period
        hold(0, 1, 10); hold(1, 1, 10); hold(1, 0, 10); hold(0, 0, 10);
        chk_int("R5", "repeated start count", n_rstart, 1);
        chk("R5", "busy_o after repeated start", busy_o, 1);

        send_bit(0); send_bit(1);

        // R4: Stop
        hold(0, 0, 10); hold(1, 0, 10); hold(1, 1, 12);
        chk("R4", "busy_o after stop", busy_o, 0);
        chk_int("R4", "stop count", n_stop, 1);

        // R8: clock pulse while idle
        hold(0, 1, 10); hold(1, 1, 12);
        chk_int("R8", "violation count", n_viol, 1);

        chk_int("R3", "start count", n_start, 2);
        // R7: the fall after the repeated Start produced no bit; the spike added none
        chk_int("R7", "recovered bit count", n_bits, 6);
        for (int i = 0; i < 6; i++) begin
            if (i < bits_q.size()) chk("R6", $sformatf("bit %0d", i), bits_q[i], exp_bits[i]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule